// File: doc/BRIEF.md
# DMA Request-Driven Burst Sequencer

This block drives a single DMA channel. Software programs a total byte count, a burst size code and an enable bit, then pulses a start input. While the transfer runs, the channel watches one peripheral request line, picked by a select field from a wide request vector. Each time that line is high while the channel is waiting, the channel issues one burst command toward a memory port. The command's byte count is the programmed burst size, or whatever is left of the total if that is smaller.

Once a burst has been accepted, the request line is not looked at again until the memory side signals that the burst's data movement has finished. The remaining count is reduced at that point. When it reaches zero, the channel returns to idle and sets a sticky, active-high interrupt. Software clears the interrupt with a one-cycle clear pulse.

If the enable bit is dropped during a transfer, the burst already under way still finishes. After that the channel goes idle without raising the interrupt.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, `cmd_valid` and `irq` are both low.
- R2: The burst size code maps as follows: 0 gives 8 bytes, 1 gives 16 bytes, and 2 or 3 give 32 bytes. Each command carries `cmd_bytes` equal to the smaller of the burst size and the remaining count.
- R3: Only the request line indexed by `req_sel` can start a burst. A high level on any other line has no effect. Each acceptance produces exactly one command.
- R4: Once raised, `cmd_valid` stays high with `cmd_bytes` unchanged until a cycle in which `cmd_ready` is high.
- R5: From the handshake cycle until `burst_done`, request lines are ignored and `cmd_valid` stays low.
- R6: Each `burst_done` reduces the remaining count by that burst's byte count. As a result, the last burst of a transfer carries only the leftover bytes.
- R7: `irq` rises in the cycle after the `burst_done` that brings the remaining count to zero. It stays high until an `irq_clr` pulse, and it rises for no other reason except R8.
- R8: A start with `cfg_en` high and `cfg_len` of zero issues no burst and sets `irq` in the next cycle.
- R9: If `cfg_en` is low when a burst completes and bytes remain, the channel goes idle, issues no further command and leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_lines | input | NUM_REQ | Level peripheral request vector |
| req_sel | input | SEL_W | Index of the request line serving this channel |
| cfg_len | input | LEN_W | Total transfer length in bytes |
| cfg_bsize | input | 2 | Burst size code (0:8, 1:16, 2/3:32) |
| cfg_en | input | 1 | Channel enable |
| start | input | 1 | Pulse: load length and begin, when idle |
| irq_clr | input | 1 | Pulse: clear the interrupt |
| cmd_valid | output | 1 | Burst command present |
| cmd_ready | input | 1 | Memory port accepts the command |
| cmd_bytes | output | 6 | Byte count of the current burst |
| burst_done | input | 1 | Pulse: data movement of the accepted burst finished |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions take two things for granted about the memory side. First, `burst_done` only pulses after a command has been accepted. Second, that pulse comes at most once per accepted command. They also assume the configuration inputs stay steady while a transfer is active. The bench's memory model honours all of this: it raises `cmd_ready` only while `cmd_valid` is high, pulses `burst_done` once per handshake after a random delay, and changes the length, size and select inputs only between transfers. The enable bit is the one deliberate exception, since the disable scenario depends on changing it mid-transfer.

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int NUM_REQ = 38,
  parameter int LEN_W   = 16,
  localparam int SEL_W  = $clog2(NUM_REQ),
  localparam int BYTE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_lines,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [1:0]         cfg_bsize,
  input  logic               cfg_en,
  input  logic               start,
  input  logic               irq_clr,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [BYTE_W-1:0]  cmd_bytes,
  input  logic               burst_done,
  output logic               irq
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ISSUE, S_BUSY} state_t;

  state_t              state;
  logic [LEN_W-1:0]    remain;
  logic [BYTE_W-1:0]   burst_bytes;
  logic [BYTE_W-1:0]   size_bytes;
  logic [BYTE_W-1:0]   next_bytes;
  logic [LEN_W-1:0]    left_after;
  logic                req_hit;

  assign req_hit    = (int'(req_sel) < NUM_REQ) ? req_lines[req_sel] : 1'b0;
  assign size_bytes = (cfg_bsize == 2'd0) ? BYTE_W'(8) :
                      (cfg_bsize == 2'd1) ? BYTE_W'(16) : BYTE_W'(32);
  assign next_bytes = (remain < LEN_W'(size_bytes)) ? remain[BYTE_W-1:0] : size_bytes;
  assign left_after = remain - LEN_W'(burst_bytes);

  assign cmd_valid = (state == S_ISSUE);
  assign cmd_bytes = burst_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      remain      <= '0;
      burst_bytes <= '0;
      irq         <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && cfg_en) begin
            if (cfg_len == '0) irq <= 1'b1;
            else begin
              remain <= cfg_len;
              state  <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (!cfg_en) state <= S_IDLE;
          else if (req_hit) begin
            burst_bytes <= next_bytes;
            state       <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (cmd_ready) state <= S_BUSY;
        end
        S_BUSY: begin
          if (burst_done) begin
            remain <= left_after;
            if (left_after == '0) begin
              irq   <= 1'b1;
              state <= S_IDLE;
            end else if (!cfg_en) state <= S_IDLE;
            else state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [5:0] cmd_bytes,
  input logic       burst_done,
  input logic       start,
  input logic       irq_clr,
  input logic       irq
);

  logic inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 1'b0;
    else if (cmd_valid && cmd_ready) inflight <= 1'b1;
    else if (burst_done) inflight <= 1'b0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !cmd_valid && !irq); // R1
  AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_bytes != 6'd0) && (cmd_bytes <= 6'd32)); // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_bytes)); // R4
  AST_NO_CMD_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> !cmd_valid); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(burst_done) || $past(start)); // R7

endmodule

bind dma_burst_seq dma_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_bytes(cmd_bytes), .burst_done(burst_done), .start(start),
  .irq_clr(irq_clr), .irq(irq)
);

// File: tb/dma_burst_seq_tb.sv
module dma_burst_seq_tb;
  localparam int NUM_REQ = 38;
  localparam int LEN_W   = 16;
  localparam int SEL_W   = $clog2(NUM_REQ);

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_REQ-1:0] req_lines;
  logic [SEL_W-1:0]   req_sel;
  logic [LEN_W-1:0]   cfg_len;
  logic [1:0]         cfg_bsize;
  logic               cfg_en, start, irq_clr, cmd_ready, burst_done;
  logic               cmd_valid, irq;
  logic [5:0]         cmd_bytes;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  dma_burst_seq #(.NUM_REQ(NUM_REQ), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .req_sel(req_sel),
    .cfg_len(cfg_len), .cfg_bsize(cfg_bsize), .cfg_en(cfg_en), .start(start),
    .irq_clr(irq_clr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bytes(cmd_bytes), .burst_done(burst_done), .irq(irq)
  );

  function automatic int size_of(input logic [1:0] code);
    return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
  endfunction

  function automatic int exp_bytes(input int rem, input logic [1:0] code);
    return (rem < size_of(code)) ? rem : size_of(code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rand_req(input int sel, input bit sel_val);
    logic [NUM_REQ-1:0] v;
    v = NUM_REQ'({$urandom(), $urandom()});
    v[sel] = sel_val;
    req_lines = v;
  endtask

  task automatic wait_cmd(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (cmd_valid) got = 1'b1;
    end
  endtask

  task automatic do_burst(input int sel, input int exp_b);
    bit got;
    int hold;
    logic [5:0] seen;
    wait_cmd(got);
    check(got, "R3", int'(got), 1);
    if (!got) return;
    check(int'(cmd_bytes) == exp_b, "R2/R6", int'(cmd_bytes), exp_b);
    seen = cmd_bytes;
    hold = $urandom_range(0, 3);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(cmd_valid && cmd_bytes == seen, "R4", int'(cmd_bytes), int'(seen));
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    for (int i = 0; i < $urandom_range(1, 6); i++) begin
      rand_req(sel, 1'b1);
      @(negedge clk);
      check(!cmd_valid, "R5", int'(cmd_valid), 0);
    end
    burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(!irq, "R7", int'(irq), 0);
  endtask

  task automatic run_xfer(input int len, input logic [1:0] bs, input int sel);
    int rem, nb;
    cfg_len = LEN_W'(len); cfg_bsize = bs; req_sel = SEL_W'(sel); cfg_en = 1'b1;
    rand_req(sel, 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rem = len; nb = 0;
    while (rem > 0) begin
      check(!irq, "R7", int'(irq), 0);
      do_burst(sel, exp_bytes(rem, bs));
      rem -= exp_bytes(rem, bs);
      nb++;
    end
    check(irq, "R7", int'(irq), 1);
    check(nb == (len + size_of(bs) - 1) / size_of(bs), "R6", nb, (len + size_of(bs) - 1) / size_of(bs));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(irq && !cmd_valid, "R7", int'(irq), 1);
    end
    clear_irq();
  endtask

  initial begin
    bit got;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_lines = '0; req_sel = '0; cfg_len = '0; cfg_bsize = '0;
    cfg_en = 1'b0; start = 1'b0; irq_clr = 1'b0; cmd_ready = 1'b0; burst_done = 1'b0;
    repeat (3) @(negedge clk);
    check(!cmd_valid && !irq, "R1", int'({cmd_valid, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: each size code, with a short tail
    run_xfer(20, 2'd0, 0);
    run_xfer(40, 2'd1, 37);
    run_xfer(70, 2'd2, 12);
    run_xfer(31, 2'd3, 4);
    run_xfer(5, 2'd2, 9);

    // R3: a non-selected line does not start a burst
    cfg_len = 16'd16; cfg_bsize = 2'd0; req_sel = 6'd5; cfg_en = 1'b1;
    req_lines = '1; req_lines[5] = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!cmd_valid, "R3", int'(cmd_valid), 0);
    end
    req_lines[5] = 1'b1;
    do_burst(5, 8);
    do_burst(5, 8);
    check(irq, "R7", int'(irq), 1);
    clear_irq();

    // R8: zero length
    cfg_len = '0; start = 1'b1; @(negedge clk); start = 1'b0;
    check(irq, "R8", int'(irq), 1);
    req_lines = '1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!cmd_valid, "R8", int'(cmd_valid), 0);
    end
    clear_irq();

    // R9: disable mid-transfer
    cfg_len = 16'd100; cfg_bsize = 2'd0; req_sel = 6'd2; cfg_en = 1'b1; req_lines = '1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    do_burst(2, 8);
    wait_cmd(got);
    check(got, "R9", int'(got), 1);
    cfg_en = 1'b0;
    do_burst(2, 8);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      check(!cmd_valid && !irq, "R9", int'({cmd_valid, irq}), 0);
    end

    // random transfers
    for (int t = 0; t < 25; t++)
      run_xfer($urandom_range(1, 200), 2'($urandom_range(0, 3)), $urandom_range(0, NUM_REQ - 1));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule